// File: doc/BRIEF.md
# Step-Enabled Non-Restoring Integer Divider

This block divides a double-width or single-width dividend by a single-width divisor, with either two's-complement or unsigned operands. It uses a non-restoring add/subtract recurrence. The operation does not run freely. It advances one step only in a cycle where `step_en` is high. A controller can therefore hold the division at any cycle boundary, for example while it services something else, and resume it later with the partial state intact.

An operation always takes exactly 19 enabled steps with the default 16-bit width:

- one setup step, which takes magnitudes, records signs and pre-checks overflow;
- 16 quotient steps;
- one step that corrects the remainder;
- one step that applies signs and writes the outputs.

Quotients truncate toward zero, and a nonzero remainder carries the sign of the dividend. A zero divisor, or a quotient outside the 16-bit result range, raises `overflow`. In that case the quotient and remainder values are not defined.

Top module: `div_iter_nr`

## Requirements
- R1: When `busy` is low, a high `start` captures `dividend`, `divisor`, `signed_mode` and `long_mode`. In the next cycle `busy` is 1 and `done` is 0. A `start` that arrives while `busy` is high is ignored and does not change the running result.
- R2: After an accepted start, `busy` stays high through the first 18 enabled steps. On the clock edge of the 19th cycle that has `step_en` high, `busy` falls and `done` rises. `busy` and `done` are never high together.
- R3: While `busy` is high and `step_en` is low, the division makes no progress, `busy` stays high, and `quotient`, `remainder` and `overflow` do not change. Any number of such pauses, at any step, leaves the final result unchanged.
- R4: Unsigned mode (`signed_mode`=0) returns the floor quotient and the remainder of the dividend divided by the divisor.
- R5: Signed mode (`signed_mode`=1) treats operands as two's complement. It returns the quotient truncated toward zero and a remainder with the sign of the dividend (dividend = quotient*divisor + remainder).
- R6: With `long_mode`=0 only `dividend[15:0]` is used. It is sign-extended in signed mode and zero-extended in unsigned mode, and `dividend[31:16]` has no effect. With `long_mode`=1 all 32 bits are used.
- R7: `overflow` is 1 when the divisor is zero, or when the true quotient lies outside 0..65535 (unsigned) or -32768..32767 (signed). Otherwise it is 0.
- R8: Once `done` is high, `done`, `quotient`, `remainder` and `overflow` keep their values until the next accepted `start`, whatever `step_en` does.
- R9: A synchronous active-high `rst` clears `busy`, `done`, `quotient`, `remainder` and `overflow` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; taken only when idle |
| dividend | input | 32 | Dividend; only the low half is used when `long_mode` is 0 |
| divisor | input | 16 | Divisor |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| long_mode | input | 1 | 1 = 32-bit dividend, 0 = 16-bit dividend |
| step_en | input | 1 | Advance the operation by one step in this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | A result is available and held |
| quotient | output | 16 | Quotient |
| remainder | output | 16 | Remainder |
| overflow | output | 1 | Divide by zero or quotient out of range |

## Verification
A wrong step counter shows at the ports as `busy` falling too early or too late, measured against the bench's own count of enabled cycles. It is therefore visible on the edge where the 19th step lands. A partial remainder or quotient register that moves while `step_en` is low, or that takes a wrong add/subtract decision, does not show until completion. It then appears as a wrong quotient or remainder against the reference model. Random pause patterns in all four sign combinations, and in both dividend widths, expose such faults within one operation. Sign and range faults show as a wrong `overflow` flag, or as a mis-signed result, on the boundary operands.

// File: rtl/div_nr_pkg.sv
package div_nr_pkg;

  typedef enum logic [1:0] {
    PH_SETUP = 2'd0,
    PH_ITER  = 2'd1,
    PH_CORR  = 2'd2,
    PH_FINAL = 2'd3
  } phase_e;

  // total enabled steps for a divisor width: setup + W iterations + correct + finalize
  function automatic int unsigned total_steps(input int unsigned w);
    return w + 3;
  endfunction

endpackage

// File: rtl/div_nr_prep.sv
module div_nr_prep #(
  parameter int W = 16
) (
  input  logic [2*W-1:0] n_raw,
  input  logic [W-1:0]   d_raw,
  input  logic           sgn,
  input  logic           lng,
  output logic [2*W-1:0] n_mag,
  output logic [W-1:0]   d_mag,
  output logic           neg_q,
  output logic           neg_r,
  output logic           pre_ovf
);
  logic [2*W-1:0] n_ext;
  logic           n_neg;
  logic           d_neg;

  always_comb begin
    if (lng)
      n_ext = n_raw;
    else if (sgn)
      n_ext = {{W{n_raw[W-1]}}, n_raw[W-1:0]};
    else
      n_ext = {{W{1'b0}}, n_raw[W-1:0]};
    n_neg   = sgn & n_ext[2*W-1];
    d_neg   = sgn & d_raw[W-1];
    n_mag   = n_neg ? (~n_ext + 1'b1) : n_ext;
    d_mag   = d_neg ? (~d_raw + 1'b1) : d_raw;
    neg_q   = n_neg ^ d_neg;
    neg_r   = n_neg;
    // magnitude quotient needs more than W bits when high half >= divisor
    pre_ovf = (d_raw == '0) | (n_mag[2*W-1:W] >= d_mag);
  end
endmodule

// File: rtl/div_nr_step.sv
module div_nr_step #(
  parameter int W = 16
) (
  input  logic [W+1:0] p_in,
  input  logic [W-1:0] q_in,
  input  logic [W-1:0] d,
  output logic [W+1:0] p_out,
  output logic [W-1:0] q_out
);
  logic [W+1:0] shifted;
  logic [W+1:0] dx;

  always_comb begin
    shifted = {p_in[W:0], q_in[W-1]};
    dx      = {2'b00, d};
    p_out   = p_in[W+1] ? (shifted + dx) : (shifted - dx);
    q_out   = {q_in[W-2:0], ~p_out[W+1]};
  end
endmodule

// File: rtl/div_nr_fix.sv
module div_nr_fix #(
  parameter int W = 16
) (
  input  logic [W+1:0] p,
  input  logic [W-1:0] qmag,
  input  logic [W-1:0] d,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic         sgn,
  output logic [W+1:0] p_corr,
  output logic [W-1:0] q_final,
  output logic [W-1:0] r_final,
  output logic         range_ovf
);
  localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};
  logic [W-1:0] rmag;

  always_comb begin
    p_corr    = p[W+1] ? (p + {2'b00, d}) : p;
    rmag      = p[W-1:0];
    q_final   = neg_q ? (~qmag + 1'b1) : qmag;
    r_final   = neg_r ? (~rmag + 1'b1) : rmag;
    range_ovf = sgn & (neg_q ? (qmag > NEG_LIMIT) : qmag[W-1]);
  end
endmodule

// File: rtl/div_iter_nr.sv
module div_iter_nr #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [2*W-1:0] dividend,
  input  logic [W-1:0]   divisor,
  input  logic           signed_mode,
  input  logic           long_mode,
  input  logic           step_en,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   quotient,
  output logic [W-1:0]   remainder,
  output logic           overflow
);
  import div_nr_pkg::*;

  localparam int STEPS = total_steps(W);
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] ITER_LAST = CW'(W);
  localparam logic [CW-1:0] CORR_IDX  = CW'(W + 1);

  logic [2*W-1:0] n_raw;
  logic [W-1:0]   d_raw;
  logic           sgn_r, lng_r;
  logic [W+1:0]   prem;
  logic [W-1:0]   qreg;
  logic [W-1:0]   dmag;
  logic           negq_r, negr_r, ovf_r;
  logic [CW-1:0]  step_cnt;
  phase_e         phase;

  logic [2*W-1:0] n_mag;
  logic [W-1:0]   d_mag;
  logic           neg_q, neg_r, pre_ovf;
  logic [W+1:0]   p_nx, p_corr;
  logic [W-1:0]   q_nx, q_fin, r_fin;
  logic           range_ovf;

  always_comb begin
    if (step_cnt == '0)             phase = PH_SETUP;
    else if (step_cnt <= ITER_LAST) phase = PH_ITER;
    else if (step_cnt == CORR_IDX)  phase = PH_CORR;
    else                            phase = PH_FINAL;
  end

  div_nr_prep #(.W(W)) u_prep (
    .n_raw(n_raw), .d_raw(d_raw), .sgn(sgn_r), .lng(lng_r),
    .n_mag(n_mag), .d_mag(d_mag), .neg_q(neg_q), .neg_r(neg_r), .pre_ovf(pre_ovf)
  );

  div_nr_step #(.W(W)) u_step (
    .p_in(prem), .q_in(qreg), .d(dmag), .p_out(p_nx), .q_out(q_nx)
  );

  div_nr_fix #(.W(W)) u_fix (
    .p(prem), .qmag(qreg), .d(dmag), .neg_q(negq_r), .neg_r(negr_r), .sgn(sgn_r),
    .p_corr(p_corr), .q_final(q_fin), .r_final(r_fin), .range_ovf(range_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      n_raw     <= '0;
      d_raw     <= '0;
      sgn_r     <= 1'b0;
      lng_r     <= 1'b0;
      prem      <= '0;
      qreg      <= '0;
      dmag      <= '0;
      negq_r    <= 1'b0;
      negr_r    <= 1'b0;
      ovf_r     <= 1'b0;
      step_cnt  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
      overflow  <= 1'b0;
    end else if (start && !busy) begin
      n_raw    <= dividend;
      d_raw    <= divisor;
      sgn_r    <= signed_mode;
      lng_r    <= long_mode;
      step_cnt <= '0;
      busy     <= 1'b1;
      done     <= 1'b0;
    end else if (busy && step_en) begin
      case (phase)
        PH_SETUP: begin
          prem     <= {2'b00, n_mag[2*W-1:W]};
          qreg     <= n_mag[W-1:0];
          dmag     <= d_mag;
          negq_r   <= neg_q;
          negr_r   <= neg_r;
          ovf_r    <= pre_ovf;
          step_cnt <= step_cnt + 1'b1;
        end
        PH_ITER: begin
          prem     <= p_nx;
          qreg     <= q_nx;
          step_cnt <= step_cnt + 1'b1;
        end
        PH_CORR: begin
          prem     <= p_corr;
          step_cnt <= step_cnt + 1'b1;
        end
        default: begin
          quotient  <= q_fin;
          remainder <= r_fin;
          overflow  <= ovf_r | range_ovf;
          step_cnt  <= '0;
          busy      <= 1'b0;
          done      <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/div_iter_nr_chk.sv
module div_iter_nr_chk #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          step_en,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  quotient,
  input logic [W-1:0]  remainder,
  input logic          overflow,
  input logic [CW-1:0] step_cnt
);
  localparam logic [CW-1:0] LAST = CW'(W + 2);

  a_r1_start_accept: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done));

  a_r2_finish: assert property (@(posedge clk) disable iff (rst)
    (busy && step_en && step_cnt == LAST) |=> (!busy && done));

  a_r2_no_early_end: assert property (@(posedge clk) disable iff (rst)
    (busy && step_en && step_cnt != LAST) |=> busy);

  a_r2_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    step_cnt <= LAST);

  a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_en) |=> (busy && $stable(step_cnt)));

  a_r3_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !step_en) |=> ($stable(quotient) && $stable(remainder) && $stable(overflow)));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(quotient) && $stable(remainder) && $stable(overflow)));
endmodule

bind div_iter_nr div_iter_nr_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .step_en(step_en), .busy(busy), .done(done),
  .quotient(quotient), .remainder(remainder), .overflow(overflow), .step_cnt(step_cnt)
);

// File: tb/div_iter_nr_tb.sv
`timescale 1ns/1ps
module div_iter_nr_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        signed_mode = 1'b0;
  logic        long_mode = 1'b0;
  logic        step_en = 1'b0;
  logic        busy, done, overflow;
  logic [15:0] quotient, remainder;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  div_iter_nr u_dut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .signed_mode(signed_mode), .long_mode(long_mode), .step_en(step_en),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [31:0] n, input logic [15:0] d,
                                input bit sgn, input bit lng,
                                output logic [15:0] eq, output logic [15:0] er,
                                output bit eo);
    longint a, b, q, r;
    if (sgn) begin
      a = lng ? longint'($signed(n)) : longint'($signed(n[15:0]));
      b = longint'($signed(d));
    end else begin
      a = lng ? longint'(n) : longint'(n[15:0]);
      b = longint'(d);
    end
    if (b == 0) begin
      eo = 1'b1; eq = '0; er = '0;
    end else begin
      q  = a / b;
      r  = a % b;
      eo = sgn ? (q > 32767 || q < -32768) : (q > 65535);
      eq = q[15:0];
      er = r[15:0];
    end
  endfunction

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  task automatic run_div(input logic [31:0] n, input logic [15:0] d, input bit sgn,
                         input bit lng, input int pct, input bit poke);
    logic [15:0] eq, er, pq, pr;
    bit eo, en, po;
    string rq;
    int steps, guard;
    model(n, d, sgn, lng, eq, er, eo);
    rq = !lng ? "R6" : (sgn ? "R5" : "R4");
    @(negedge clk);
    dividend = n; divisor = d; signed_mode = sgn; long_mode = lng;
    start = 1'b1; step_en = 1'b1;
    @(negedge clk);
    start = 1'b0; step_en = 1'b0;
    chk(busy && !done, "R1", "busy/done after start", {busy, done}, 2'b10);
    // scramble inputs; the captured operands must be used
    dividend = $urandom; divisor = $urandom[15:0]; signed_mode = ~sgn; long_mode = ~lng;
    steps = 0; guard = 0;
    while (steps < 19 && guard < 4000) begin
      en = (($urandom % 100) < pct);
      if (poke && steps == 5) start = 1'b1;
      step_en = en;
      pq = quotient; pr = remainder; po = overflow;
      @(negedge clk);
      start = 1'b0;
      guard++;
      if (en) steps++;
      if (!en)
        chk(busy && quotient == pq && remainder == pr && overflow == po,
            "R3", "paused state changed", {busy, quotient}, {1'b1, pq});
      else if (steps < 19)
        chk(busy, "R2", "busy dropped before step 19", steps, 19);
    end
    step_en = 1'b0;
    chk(!busy && done, "R2", "busy/done after 19 steps", {busy, done}, 2'b01);
    if (eo)
      chk(overflow, "R7", "overflow flag", overflow, 1);
    else begin
      chk(!overflow, "R7", "spurious overflow", overflow, 0);
      chk(quotient == eq, poke ? "R1" : rq, "quotient", quotient, eq);
      chk(remainder == er, poke ? "R1" : rq, "remainder", remainder, er);
    end
    pq = quotient; pr = remainder; po = overflow;
    step_en = 1'b1;
    repeat (2) @(negedge clk);
    step_en = 1'b0;
    chk(done && quotient == pq && remainder == pr && overflow == po,
        "R8", "held result", {done, quotient}, {1'b1, pq});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] n;
    logic [15:0] d;
    bit s, l;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!busy && !done && quotient == 0 && remainder == 0 && !overflow,
        "R9", "reset outputs", {busy, done, overflow, quotient, remainder}, 0);

    // directed corners
    run_div(32'd100, 16'd7, 0, 1, 100, 0);            // R4 basic
    run_div(32'hFFFE_FFFF, 16'hFFFF, 0, 1, 60, 0);     // R4 largest in-range quotient
    run_div(32'h0001_0000, 16'd1, 0, 1, 100, 0);       // R7 unsigned range
    run_div(32'd1234, 16'd0, 0, 1, 100, 0);            // R7 zero divisor
    run_div(32'hFFFF_FFF9, 16'd2, 1, 1, 50, 0);        // R5 -7/2
    run_div(32'd7, 16'hFFFE, 1, 1, 50, 0);             // R5 7/-2
    run_div(32'hFFFF_FFF9, 16'hFFFE, 1, 1, 50, 0);     // R5 -7/-2
    run_div(32'h0000_8000, 16'd1, 1, 1, 100, 0);       // R7 signed +32768
    run_div(32'hFFFF_8000, 16'd1, 1, 1, 100, 0);       // R5 -32768 fits
    run_div(32'h0000_8000, 16'hFFFF, 1, 0, 100, 0);    // R7 short -32768/-1
    run_div(32'hABCD_0064, 16'd10, 0, 0, 70, 0);       // R6 upper half ignored
    run_div(32'h1234_FF9C, 16'd7, 1, 0, 70, 0);        // R6 sign-extended short
    run_div(32'd50000, 16'd123, 0, 1, 40, 1);          // R1 start while busy ignored
    run_div(32'h0000_0000, 16'd5, 1, 1, 20, 0);        // R3 heavy pausing, zero dividend

    // constrained random, all sign combinations and both widths
    for (int i = 0; i < 400; i++) begin
      s = $urandom % 2;
      l = $urandom % 2;
      d = $urandom[15:0];
      if (($urandom % 16) == 0) d = 16'd0;
      n = $urandom;
      if (l && ($urandom % 4) != 0) begin
        if (s) begin
          n = $urandom >> ($urandom % 24);
          if ($urandom % 2) n = ~n + 1;
        end else if (d != 0) begin
          n[31:16] = $urandom[15:0] % d;
        end
      end
      run_div(n, d, s, l, 30 + ($urandom % 71), ($urandom % 10) == 0);
    end

    summary();
    $finish;
  end
endmodule